// File: doc/BRIEF.md
# Exception entry and return sequencer

This block handles the control side of taking and leaving an exception in a 32-bit scalar core with branch delay slots. When the pipeline raises an exception, it supplies a vector number, the address of the faulting instruction, a flag saying whether that instruction sat in a delay slot, and the live status register. One clock later the block has updated its saved-PC, saved-status and fault-address registers. It has also produced the new status word with the delay-slot-exception bit filled in and a pulse that cancels any pending delay slot. Finally it issues a one-cycle redirect to the handler address.

A return-from-exception strobe reverses the process. It supplies the saved status word, with the fixed-one bit forced high, for the status register, and it redirects fetch to the saved PC. A separate trap request never vectors: it pulses a halt-to-debugger output together with the trapping PC. A vector number the block does not support raises a one-cycle error pulse and leaves every register untouched.

The vector codes are 1 reset, 2 bus error, 6 alignment, 7 illegal instruction, 11 range, 12 system call and 13 floating point. In the status word, bit 13 records the delay-slot exception, bit 14 selects the high handler base and bit 15 is the fixed-one bit.

Top module: `exc_seq`

## Requirements
- R1: A trap request (`trap_i`) pulses `halt_o` high for one cycle on the next clock edge and loads `halt_pc_o` with `exc_pc_i`. No redirect, status write or register update follows it.
- R2: For vector 12 (system call) and vector 13 (floating point), `epcr_o` becomes `exc_pc_i + 4` when `in_ds_i` is 0, and `exc_pc_i` when `in_ds_i` is 1.
- R3: For vector 2 (bus error), 6 (alignment), 7 (illegal) and 11 (range), `epcr_o` becomes `exc_pc_i` when `in_ds_i` is 0, and `exc_pc_i - 4` when `in_ds_i` is 1.
- R4: Vector 1 (reset) leaves `epcr_o` unchanged, while still vectoring and saving the status.
- R5: Every vectored exception copies `sr_i` in full into `esr_o`.
- R6: Every vectored exception pulses `sr_we_o` and `clr_ds_o` for one cycle. `sr_wdata_o` equals `sr_i` with bit 13 replaced by `in_ds_i`.
- R7: The redirect address is the vector number shifted left by 8. 0xF0000000 is added to it when bit 14 of `sr_i` is 1, and nothing is added when that bit is 0.
- R8: Vector 7 also loads `eear_o` with the unadjusted `exc_pc_i`. Every other vector leaves `eear_o` unchanged.
- R9: The `rfe_i` strobe pulses `sr_we_o`, `clr_ds_o` and `redir_valid_o`. It drives `sr_wdata_o` to `esr_o` with bit 15 set, and it drives `redir_pc_o` to `epcr_o`.
- R10: Any vector other than 1, 2, 6, 7, 11, 12 or 13 pulses `err_o` for one cycle. It changes no register and raises no redirect or status write.
- R11: All outputs are registered and appear on the clock edge that samples the request. Pulses last one cycle. Priority runs trap, then exception, then return. At most one of `redir_valid_o`, `halt_o` and `err_o` is high at a time.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request |
| exc_vec_i | input | 4 | Exception vector number |
| exc_pc_i | input | 32 | Address of faulting or trapping instruction |
| in_ds_i | input | 1 | Faulting instruction is in a delay slot |
| sr_i | input | 32 | Current status register |
| rfe_i | input | 1 | Return-from-exception strobe |
| trap_i | input | 1 | Trap request, halts to debugger |
| redir_valid_o | output | 1 | Redirect strobe, one cycle |
| redir_pc_o | output | 32 | Redirect target |
| sr_we_o | output | 1 | Status register write strobe |
| sr_wdata_o | output | 32 | New status register value |
| clr_ds_o | output | 1 | Cancel pending delay slot |
| epcr_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved exception status |
| eear_o | output | 32 | Effective address of illegal instruction |
| halt_o | output | 1 | Halt to debugger, one cycle |
| halt_pc_o | output | 32 | PC reported with the halt |
| err_o | output | 1 | Unsupported vector, one cycle |

## Verification
Every saved register is visible at a port, so a wrong PC adjustment, a missed status copy or a stray fault-address write shows on the edge after the request. The bench catches it at the next half period. Stale or wrongly cleared saved state also surfaces through the return path. A later return redirects to the wrong address or restores the wrong status word, which is why the stimulus pairs each exception class with a following return. A broken priority between trap, exception and return shows up as the wrong pulse, or two pulses, in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned SR_DSX_BIT = 13;
  localparam int unsigned SR_EPH_BIT = 14;
  localparam int unsigned SR_FO_BIT  = 15;

  localparam logic [3:0] VEC_RESET   = 4'd1;
  localparam logic [3:0] VEC_BUS     = 4'd2;
  localparam logic [3:0] VEC_ALIGN   = 4'd6;
  localparam logic [3:0] VEC_ILLEGAL = 4'd7;
  localparam logic [3:0] VEC_RANGE   = 4'd11;
  localparam logic [3:0] VEC_SYSCALL = 4'd12;
  localparam logic [3:0] VEC_FPE     = 4'd13;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_RESET = 2'd1,
    CLS_NEXT  = 2'd2,  // resume after faulting insn
    CLS_CUR   = 2'd3   // re-execute faulting insn
  } exc_cls_e;
endpackage

// File: rtl/exc_class_dec.sv
module exc_class_dec
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W = 4
) (
  input  logic [VEC_W-1:0] vec_i,
  output exc_cls_e         cls_o,
  output logic             illegal_o
);
  always_comb begin
    cls_o     = CLS_NONE;
    illegal_o = 1'b0;
    case (4'(vec_i))
      VEC_RESET:                  cls_o = CLS_RESET;
      VEC_SYSCALL, VEC_FPE:       cls_o = CLS_NEXT;
      VEC_BUS, VEC_ALIGN,
      VEC_RANGE:                  cls_o = CLS_CUR;
      VEC_ILLEGAL: begin
        cls_o     = CLS_CUR;
        illegal_o = 1'b1;
      end
      default:                    cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int unsigned      XLEN          = 32,
  parameter int unsigned      VEC_W         = 4,
  parameter int unsigned      INSN_BYTES    = 4,
  parameter int unsigned      HANDLER_SHIFT = 8,
  parameter logic [XLEN-1:0]  PREFIX_BASE   = 32'hF000_0000
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic             ds_i,
  input  exc_cls_e         cls_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             eph_i,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  handler_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] base_pc;

  always_comb begin
    base_pc = (cls_i == CLS_NEXT) ? pc_i + STEP : pc_i;
    epc_o   = ds_i ? base_pc - STEP : base_pc;
  end

  assign handler_o = (eph_i ? PREFIX_BASE : '0) + (XLEN'(vec_i) << HANDLER_SHIFT);
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     VEC_W         = 4,
  parameter int unsigned     INSN_BYTES    = 4,
  parameter int unsigned     HANDLER_SHIFT = 8,
  parameter logic [XLEN-1:0] PREFIX_BASE   = 32'hF000_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_req_i,
  input  logic [VEC_W-1:0] exc_vec_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic             in_ds_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic             rfe_i,
  input  logic             trap_i,
  output logic             redir_valid_o,
  output logic [XLEN-1:0]  redir_pc_o,
  output logic             sr_we_o,
  output logic [XLEN-1:0]  sr_wdata_o,
  output logic             clr_ds_o,
  output logic [XLEN-1:0]  epcr_o,
  output logic [XLEN-1:0]  esr_o,
  output logic [XLEN-1:0]  eear_o,
  output logic             halt_o,
  output logic [XLEN-1:0]  halt_pc_o,
  output logic             err_o
);
  exc_cls_e        cls;
  logic            is_illegal;
  logic [XLEN-1:0] epc_calc;
  logic [XLEN-1:0] handler_pc;
  logic            take_trap, take_exc, take_rfe, vec_ok;
  logic [XLEN-1:0] sr_entry;

  exc_class_dec #(.VEC_W(VEC_W)) u_dec (
    .vec_i     (exc_vec_i),
    .cls_o     (cls),
    .illegal_o (is_illegal)
  );

  exc_target #(
    .XLEN(XLEN), .VEC_W(VEC_W), .INSN_BYTES(INSN_BYTES),
    .HANDLER_SHIFT(HANDLER_SHIFT), .PREFIX_BASE(PREFIX_BASE)
  ) u_tgt (
    .pc_i      (exc_pc_i),
    .ds_i      (in_ds_i),
    .cls_i     (cls),
    .vec_i     (exc_vec_i),
    .eph_i     (sr_i[SR_EPH_BIT]),
    .epc_o     (epc_calc),
    .handler_o (handler_pc)
  );

  assign take_trap = trap_i;
  assign take_exc  = exc_req_i & ~trap_i;
  assign take_rfe  = rfe_i & ~exc_req_i & ~trap_i;
  assign vec_ok    = (cls != CLS_NONE);

  always_comb begin
    sr_entry             = sr_i;
    sr_entry[SR_DSX_BIT] = in_ds_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      sr_we_o       <= 1'b0;
      sr_wdata_o    <= '0;
      clr_ds_o      <= 1'b0;
      epcr_o        <= '0;
      esr_o         <= '0;
      eear_o        <= '0;
      halt_o        <= 1'b0;
      halt_pc_o     <= '0;
      err_o         <= 1'b0;
    end else begin
      redir_valid_o <= 1'b0;
      sr_we_o       <= 1'b0;
      clr_ds_o      <= 1'b0;
      halt_o        <= 1'b0;
      err_o         <= 1'b0;
      if (take_trap) begin
        halt_o    <= 1'b1;
        halt_pc_o <= exc_pc_i;
      end else if (take_exc) begin
        if (vec_ok) begin
          if (cls != CLS_RESET) epcr_o <= epc_calc;
          if (is_illegal)       eear_o <= exc_pc_i;
          esr_o         <= sr_i;
          sr_wdata_o    <= sr_entry;
          sr_we_o       <= 1'b1;
          clr_ds_o      <= 1'b1;
          redir_valid_o <= 1'b1;
          redir_pc_o    <= handler_pc;
        end else begin
          err_o <= 1'b1;
        end
      end else if (take_rfe) begin
        sr_wdata_o            <= esr_o;
        sr_wdata_o[SR_FO_BIT] <= 1'b1;
        sr_we_o               <= 1'b1;
        clr_ds_o              <= 1'b1;
        redir_valid_o         <= 1'b1;
        redir_pc_o            <= epcr_o;
      end
    end
  end

  p_trap_halt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> halt_o && !redir_valid_o && halt_pc_o == $past(exc_pc_i));

  p_cur_epc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc && cls == CLS_CUR && !in_ds_i) |=> epcr_o == $past(exc_pc_i));

  p_reset_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc && cls == CLS_RESET) |=> $stable(epcr_o) && redir_valid_o);

  p_esr_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc && vec_ok) |=> esr_o == $past(sr_i));

  p_rfe_return_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_rfe |=> redir_valid_o && sr_wdata_o[SR_FO_BIT] && redir_pc_o == $past(epcr_o));

  p_bad_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_exc && !vec_ok) |=> err_o && !sr_we_o && $stable(esr_o) && $stable(epcr_o));

  p_excl_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redir_valid_o, halt_o, err_o}));
endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, in_ds = 1'b0, rfe = 1'b0, trap = 1'b0;
  logic [3:0]  vec = '0;
  logic [31:0] pc = '0, sr = '0;
  logic        redir_valid, sr_we, clr_ds, halt, err;
  logic [31:0] redir_pc, sr_wdata, epcr, esr, eear, halt_pc;

  int checks = 0, errors = 0;

  // reference model state
  logic        m_rv = 0, m_we = 0, m_cd = 0, m_halt = 0, m_err = 0;
  logic [31:0] m_rpc = 0, m_wd = 0, m_epcr = 0, m_esr = 0, m_eear = 0, m_hpc = 0;

  always #10 clk = ~clk;

  exc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_vec_i(vec),
    .exc_pc_i(pc), .in_ds_i(in_ds), .sr_i(sr), .rfe_i(rfe), .trap_i(trap),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc), .sr_we_o(sr_we),
    .sr_wdata_o(sr_wdata), .clr_ds_o(clr_ds), .epcr_o(epcr), .esr_o(esr),
    .eear_o(eear), .halt_o(halt), .halt_pc_o(halt_pc), .err_o(err)
  );

  always @(posedge clk) begin
    m_rv = 0; m_we = 0; m_cd = 0; m_halt = 0; m_err = 0;
    if (!rst_n) begin
      m_rpc = 0; m_wd = 0; m_epcr = 0; m_esr = 0; m_eear = 0; m_hpc = 0;
    end else if (trap) begin
      m_halt = 1; m_hpc = pc;
    end else if (exc_req) begin
      if (vec inside {1, 2, 6, 7, 11, 12, 13}) begin
        if (vec == 12 || vec == 13) m_epcr = in_ds ? pc : pc + 4;
        else if (vec != 1)          m_epcr = in_ds ? pc - 4 : pc;
        if (vec == 7) m_eear = pc;
        m_esr = sr;
        m_wd  = in_ds ? (sr | 32'h2000) : (sr & ~32'h2000);
        m_we = 1; m_cd = 1; m_rv = 1;
        m_rpc = (sr[14] ? 32'hF000_0000 : 32'h0) + ({28'h0, vec} << 8);
      end else m_err = 1;
    end else if (rfe) begin
      m_wd = m_esr | 32'h8000; m_we = 1; m_cd = 1; m_rv = 1; m_rpc = m_epcr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R7/R9 redir_valid", {31'b0, redir_valid}, {31'b0, m_rv});
    chk("R7/R9 redir_pc", redir_pc, m_rpc);
    chk("R6 sr_we", {31'b0, sr_we}, {31'b0, m_we});
    chk("R6 sr_wdata", sr_wdata, m_wd);
    chk("R6 clr_ds", {31'b0, clr_ds}, {31'b0, m_cd});
    chk("R2/R3 epcr", epcr, m_epcr);
    chk("R5 esr", esr, m_esr);
    chk("R8 eear", eear, m_eear);
    chk("R1 halt", {31'b0, halt}, {31'b0, m_halt});
    chk("R1 halt_pc", halt_pc, m_hpc);
    chk("R10 err", {31'b0, err}, {31'b0, m_err});
  end

  task automatic step(input logic e, input logic [3:0] v, input logic [31:0] p,
                      input logic d, input logic [31:0] s, input logic r, input logic t);
    exc_req = e; vec = v; pc = p; in_ds = d; sr = s; rfe = r; trap = t;
    @(posedge clk); #1;
    exc_req = 0; rfe = 0; trap = 0;
    @(negedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R12 redir_valid", {31'b0, redir_valid}, 0);
        chk("R12 epcr", epcr, 0);
        chk("R12 sr_wdata", sr_wdata, 0);
        chk("R12 halt/err", {30'b0, halt, err}, 0);
        rst_n = 1;
        @(negedge clk);
        step(1, 12, 32'h1000, 0, 32'h8001, 0, 0);
        chk("R2 syscall epcr", epcr, 32'h1004);
        chk("R7 low base", redir_pc, 32'h0000_0C00);
        chk("R5 esr", esr, 32'h8001);
        chk("R6 dsx clear", sr_wdata, 32'h8001);
        step(1, 13, 32'h2000, 1, 32'h4000, 0, 0);
        chk("R2 fpe ds epcr", epcr, 32'h2000);
        chk("R7 high base", redir_pc, 32'hF000_0D00);
        chk("R6 dsx set", sr_wdata, 32'h6000);
        step(1, 6, 32'h3000, 0, 32'h0, 0, 0);
        chk("R3 align epcr", epcr, 32'h3000);
        step(1, 11, 32'h3010, 1, 32'h0, 0, 0);
        chk("R3 range ds epcr", epcr, 32'h300C);
        step(1, 7, 32'h4444, 1, 32'h12, 0, 0);
        chk("R3 illegal ds epcr", epcr, 32'h4440);
        chk("R8 eear loaded", eear, 32'h4444);
        step(1, 2, 32'h5000, 0, 32'h0, 0, 0);
        chk("R8 eear kept", eear, 32'h4444);
        step(1, 1, 32'h9999, 0, 32'h4000, 0, 0);
        chk("R4 epcr kept", epcr, 32'h5000);
        chk("R4 reset handler", redir_pc, 32'hF000_0100);
        step(1, 5, 32'h6000, 0, 32'hABCD, 0, 0);
        chk("R10 err", {31'b0, err}, 1);
        chk("R10 no redirect", {31'b0, redir_valid}, 0);
        chk("R10 esr kept", esr, 32'h4000);
        step(0, 0, 32'h0, 0, 32'h0, 1, 0);
        chk("R9 rfe sr", sr_wdata, 32'hC000);
        chk("R9 rfe pc", redir_pc, 32'h5000);
        step(1, 12, 32'h7777, 0, 32'h0, 1, 1);
        chk("R1 halt", {31'b0, halt}, 1);
        chk("R1 halt pc", halt_pc, 32'h7777);
        chk("R11 trap first", {31'b0, redir_valid}, 0);
        step(1, 2, 32'h8000, 0, 32'h0, 1, 0);
        chk("R11 exc over rfe", redir_pc, 32'h200);
        @(negedge clk);
        chk("R11 single pulse", {29'b0, redir_valid, sr_we, clr_ds}, 0);
        repeat (2) @(negedge clk);
      end
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hang expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule